// File: doc/BRIEF.md
# Firmware Image Stream Loader

This block takes an engine firmware image as a stream of 32-bit words, checks it, and turns every payload word into a write command for the engine's instruction memory or data memory. The image has a three-word header (magic, identity word, payload size in words). The payload opens with a block table and carries code blocks at the word offsets that the table lists. Each code block has a start address and a length, followed by its data words. The host sets the total image length in bytes, the engine number and the device-family flag, and then pulses `start`.

Both data paths use valid/ready. A word moves on `s_data` only in a cycle where `s_valid` and `s_ready` are both high. While a code block's data is flowing, the write port passes words straight through: `wr_valid` follows `s_valid`, `s_ready` follows `wr_ready`, and a low `wr_ready` therefore stalls the image stream with no buffering in between. In every other state, `s_ready` reflects only the parser's own need for a word. The loader can detect a byte-reversed image from its magic word, and in that case it reverses the bytes of every later word as it arrives. It checks all offsets and bounds before it issues any write of the block concerned. After the first error it stops and holds a nonzero error code.

Top module: `fwl_loader`

## Requirements
- R1: `s_ready` is low while idle, after completion and after an error. While a code block's data flows, `wr_valid` equals `s_valid`, `s_ready` equals `wr_ready`, and a word is consumed only when both are high.
- R2: A first word of 0xFEEDF00D selects native byte order. A first word of 0x0DF0EDFE selects reversed order, and every later word is then byte-reversed before use. Any other first word gives error code 1.
- R3: The size word times four plus 12 must equal `img_bytes`, otherwise error code 2 is reported.
- R4: Identity bits 27:24 must equal `engine_id`, otherwise error code 3 is reported. When `legacy_family` is high, a nonzero value in identity bits 31:28 gives error code 4.
- R5: A table entry is laid out as type in bits 31:24 and word offset in bits 23:0, with offsets counted from the first payload word. Type 0x00 selects instruction memory, 0x01 selects data memory and 0x0F ends the table. Any other type gives error code 8. Reaching the payload size without an end entry gives error code 5. More than MAX_BLOCKS entries gives error code 6.
- R6: Every offset plus 2 must not exceed the payload size, and every offset must be at least the entry count plus one. A violation of either gives error code 7.
- R7: Blocks are loaded in table order. If a block's offset lies behind the stream position already reached (overlap or descending order), error code 9 is reported. Words between blocks are consumed and discarded.
- R8: A code block is a start address word, a length word and then its data words. Start plus length above the target memory size gives error code 10. Offset plus 2 plus length above the payload size gives error code 11. Both checks are made before any write of that block.
- R9: On the legacy family, instruction memory holds 4096 words for engine 0 and 2048 words for the other engines, and data memory holds 2048 words. On the newer family, both memories hold 4096 words.
- R10: Data words are written to consecutive addresses, starting at the block's start address. `wr_sel` is 0 for instruction memory and 1 for data memory.
- R11: After the last write of the last block, or on the end entry of an empty table, `done` pulses for one cycle while `err_code` is 0.
- R12: Once an error occurs, no further write is issued and `err_code` holds its value until the next `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new image; clears the error code |
| engine_id | input | 4 | Engine number the image must target |
| legacy_family | input | 1 | High selects the older device family |
| img_bytes | input | 32 | Total image length in bytes |
| s_valid | input | 1 | Image word valid |
| s_data | input | 32 | Image word |
| s_ready | output | 1 | Loader accepts the word |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_sel | output | 1 | 0 instruction memory, 1 data memory |
| wr_addr | output | ADDR_W | Word address of the write |
| wr_data | output | 32 | Write data, in native byte order |
| done | output | 1 | One-cycle pulse on successful completion |
| err_code | output | 4 | Error code, 0 when there is no error |

## Verification
A two-block image with a gap word is sent once in native byte order, with a steady stream and an always-ready write port. It is then sent byte-reversed, with input bubbles and write back-pressure. Writes that match across both runs separate the swap logic and the handshake coupling from the address sequencing. Single-fault images then hit one check each: magic, size, engine, family, missing end entry, low offset, bad type, full table, overlap, memory bound and image bound. A block that ends exactly at a memory's top, with the same image sent to engine 0 and then to engine 1, shows the family and engine memory sizes. An image whose second block fails after its first block loads shows that writes stop at the error and not earlier.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  localparam logic [31:0] FW_MAGIC     = 32'hFEEDF00D;
  localparam logic [31:0] FW_MAGIC_REV = 32'h0DF0EDFE;
  localparam int          OFF_W        = 24;

  localparam logic [7:0] BT_INSTR = 8'h00;
  localparam logic [7:0] BT_DATA  = 8'h01;
  localparam logic [7:0] BT_END   = 8'h0F;

  typedef enum logic [3:0] {
    E_NONE   = 4'd0,
    E_MAGIC  = 4'd1,
    E_SIZE   = 4'd2,
    E_ENGINE = 4'd3,
    E_FAMILY = 4'd4,
    E_NOEND  = 4'd5,
    E_FULL   = 4'd6,
    E_OFFSET = 4'd7,
    E_TYPE   = 4'd8,
    E_ORDER  = 4'd9,
    E_MEM    = 4'd10,
    E_IMG    = 4'd11
  } fwl_err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_MAGIC, S_ID, S_SIZE, S_TABLE, S_SEEK,
    S_CB_ADDR, S_CB_LEN, S_DATA, S_ERR
  } fwl_st_e;
endpackage

// File: rtl/fwl_swap.sv
module fwl_swap #(
  parameter int WORD_W = 32
) (
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int NB = WORD_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign dout[8*b +: 8] = en ? din[8*(NB-1-b) +: 8] : din[8*b +: 8];
  end
endmodule

// File: rtl/fwl_table.sv
module fwl_table #(
  parameter int DEPTH = 8,
  parameter int OW    = 24,
  parameter int IW    = $clog2(DEPTH + 1),
  parameter int XW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic          wsel,
  input  logic [OW-1:0] woff,
  input  logic [XW-1:0] ridx,
  output logic          rsel,
  output logic [OW-1:0] roff,
  output logic [IW-1:0] cnt,
  output logic          full,
  input  logic [OW-1:0] limit,
  output logic          below
);
  logic [OW-1:0] off_q [DEPTH];
  logic          sel_q [DEPTH];
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        off_q[i] <= '0;
        sel_q[i] <= 1'b0;
      end
    end else if (clr) begin
      cnt_q <= '0;
    end else if (we && !full) begin
      off_q[cnt_q[XW-1:0]] <= woff;
      sel_q[cnt_q[XW-1:0]] <= wsel;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    below = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((IW'(i) < cnt_q) && (off_q[i] < limit)) below = 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign full = (cnt_q == IW'(DEPTH));
  assign rsel = sel_q[ridx];
  assign roff = off_q[ridx];

  AST_TBL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |-> (cnt_q < IW'(DEPTH))); // R5
endmodule

// File: rtl/fwl_bounds.sv
module fwl_bounds #(
  parameter int OW          = 24,
  parameter int LEG_IMEM_E0 = 4096,
  parameter int LEG_IMEM    = 2048,
  parameter int LEG_DMEM    = 2048,
  parameter int NEW_MEM     = 4096
) (
  input  logic          legacy,
  input  logic [3:0]    engine,
  input  logic          sel,
  input  logic [31:0]   start_addr,
  input  logic [31:0]   len,
  input  logic [OW-1:0] offset,
  input  logic [31:0]   size,
  output logic [31:0]   cap,
  output logic          mem_ovf,
  output logic          img_ovf
);
  always_comb begin
    if (!legacy)           cap = 32'(NEW_MEM);
    else if (sel)          cap = 32'(LEG_DMEM);
    else if (engine == '0) cap = 32'(LEG_IMEM_E0);
    else                   cap = 32'(LEG_IMEM);
  end

  assign mem_ovf = ({1'b0, start_addr} + {1'b0, len}) > {1'b0, cap};
  assign img_ovf = ({{(34-OW){1'b0}}, offset} + 34'd2 + {2'b00, len}) > {2'b00, size};
endmodule

// File: rtl/fwl_loader.sv
module fwl_loader
  import fwl_pkg::*;
#(
  parameter int MAX_BLOCKS  = 8,
  parameter int ADDR_W      = 12,
  parameter int LEG_IMEM_E0 = 4096,
  parameter int LEG_IMEM    = 2048,
  parameter int LEG_DMEM    = 2048,
  parameter int NEW_MEM     = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        engine_id,
  input  logic              legacy_family,
  input  logic [31:0]       img_bytes,
  input  logic              s_valid,
  input  logic [31:0]       s_data,
  output logic              s_ready,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_sel,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              done,
  output logic [3:0]        err_code
);
  localparam int IW = $clog2(MAX_BLOCKS + 1);
  localparam int XW = $clog2(MAX_BLOCKS);

  fwl_st_e           st;
  fwl_err_e          err_q;
  logic              swap_q;
  logic [31:0]       size_q, pos_q, cb_start_q, rem_q;
  logic [IW-1:0]     k_q, k_nx;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic [31:0]       w;
  logic              hs;

  logic              tbl_rsel, tbl_full, tbl_below, tbl_we;
  logic [OFF_W-1:0]  tbl_roff;
  logic [IW-1:0]     tbl_cnt;
  logic [31:0]       cap;
  logic              mem_ovf, img_ovf;

  logic [7:0]        etype;
  logic [OFF_W-1:0]  eoff;
  logic              etype_ok, off_fit, last_blk, size_ok;

  fwl_swap #(.WORD_W(32)) u_swap (.en(swap_q), .din(s_data), .dout(w));

  fwl_table #(.DEPTH(MAX_BLOCKS), .OW(OFF_W), .IW(IW), .XW(XW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .clr(start), .we(tbl_we),
    .wsel(etype[0]), .woff(eoff), .ridx(k_q[XW-1:0]),
    .rsel(tbl_rsel), .roff(tbl_roff), .cnt(tbl_cnt), .full(tbl_full),
    .limit(OFF_W'(tbl_cnt) + 1'b1), .below(tbl_below)
  );

  fwl_bounds #(.OW(OFF_W), .LEG_IMEM_E0(LEG_IMEM_E0), .LEG_IMEM(LEG_IMEM),
               .LEG_DMEM(LEG_DMEM), .NEW_MEM(NEW_MEM)) u_bnd (
    .legacy(legacy_family), .engine(engine_id), .sel(tbl_rsel),
    .start_addr(cb_start_q), .len(w), .offset(tbl_roff), .size(size_q),
    .cap(cap), .mem_ovf(mem_ovf), .img_ovf(img_ovf)
  );

  assign etype    = w[31:24];
  assign eoff     = w[OFF_W-1:0];
  assign etype_ok = (etype == BT_INSTR) || (etype == BT_DATA);
  assign off_fit  = ({{(33-OFF_W){1'b0}}, eoff} + 33'd2) <= {1'b0, size_q};
  assign k_nx     = k_q + 1'b1;
  assign last_blk = (k_nx == tbl_cnt);
  assign size_ok  = ({1'b0, w, 2'b00} + 35'd12) == {3'b000, img_bytes};

  always_comb begin
    case (st)
      S_MAGIC, S_ID, S_SIZE, S_CB_ADDR, S_CB_LEN: s_ready = 1'b1;
      S_TABLE: s_ready = (pos_q < size_q);
      S_SEEK:  s_ready = (pos_q < {{(32-OFF_W){1'b0}}, tbl_roff});
      S_DATA:  s_ready = wr_ready;
      default: s_ready = 1'b0;
    endcase
  end

  assign hs     = s_valid && s_ready;
  assign tbl_we = (st == S_TABLE) && hs && (pos_q < size_q) && (etype != BT_END)
                  && etype_ok && !tbl_full && off_fit;

  assign wr_valid = (st == S_DATA) && s_valid;
  assign wr_sel   = tbl_rsel;
  assign wr_addr  = addr_q;
  assign wr_data  = w;
  assign done     = done_q;
  assign err_code = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; err_q <= E_NONE; swap_q <= 1'b0; size_q <= '0;
      pos_q <= '0; cb_start_q <= '0; rem_q <= '0; k_q <= '0;
      addr_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        st <= S_MAGIC; err_q <= E_NONE; swap_q <= 1'b0;
        pos_q <= '0; k_q <= '0;
      end else begin
        case (st)
          S_MAGIC: if (hs) begin
            if (s_data == FW_MAGIC)          begin swap_q <= 1'b0; st <= S_ID; end
            else if (s_data == FW_MAGIC_REV) begin swap_q <= 1'b1; st <= S_ID; end
            else                             begin err_q <= E_MAGIC; st <= S_ERR; end
          end
          S_ID: if (hs) begin
            if (w[27:24] != engine_id)
              begin err_q <= E_ENGINE; st <= S_ERR; end
            else if (legacy_family && (w[31:28] != 4'h0))
              begin err_q <= E_FAMILY; st <= S_ERR; end
            else st <= S_SIZE;
          end
          S_SIZE: if (hs) begin
            if (!size_ok) begin err_q <= E_SIZE; st <= S_ERR; end
            else begin size_q <= w; pos_q <= '0; st <= S_TABLE; end
          end
          S_TABLE: begin
            if (pos_q >= size_q) begin
              err_q <= E_NOEND; st <= S_ERR;
            end else if (hs) begin
              pos_q <= pos_q + 1'b1;
              if (etype == BT_END) begin
                if (tbl_cnt == '0) begin done_q <= 1'b1; st <= S_IDLE; end
                else if (tbl_below) begin err_q <= E_OFFSET; st <= S_ERR; end
                else begin k_q <= '0; st <= S_SEEK; end
              end
              else if (tbl_full) begin err_q <= E_FULL;   st <= S_ERR; end
              else if (!etype_ok) begin err_q <= E_TYPE;   st <= S_ERR; end
              else if (!off_fit)  begin err_q <= E_OFFSET; st <= S_ERR; end
            end
          end
          S_SEEK: begin
            if (pos_q > {{(32-OFF_W){1'b0}}, tbl_roff})
              begin err_q <= E_ORDER; st <= S_ERR; end
            else if (pos_q == {{(32-OFF_W){1'b0}}, tbl_roff}) st <= S_CB_ADDR;
            else if (hs) pos_q <= pos_q + 1'b1;
          end
          S_CB_ADDR: if (hs) begin
            cb_start_q <= w; pos_q <= pos_q + 1'b1; st <= S_CB_LEN;
          end
          S_CB_LEN: if (hs) begin
            pos_q <= pos_q + 1'b1;
            if (mem_ovf)      begin err_q <= E_MEM; st <= S_ERR; end
            else if (img_ovf) begin err_q <= E_IMG; st <= S_ERR; end
            else if (w == '0) begin
              if (last_blk) begin done_q <= 1'b1; st <= S_IDLE; end
              else begin k_q <= k_nx; st <= S_SEEK; end
            end else begin
              rem_q <= w; addr_q <= cb_start_q[ADDR_W-1:0]; st <= S_DATA;
            end
          end
          S_DATA: if (hs) begin
            pos_q <= pos_q + 1'b1;
            addr_q <= addr_q + 1'b1;
            rem_q <= rem_q - 1'b1;
            if (rem_q == 32'd1) begin
              if (last_blk) begin done_q <= 1'b1; st <= S_IDLE; end
              else begin k_q <= k_nx; st <= S_SEEK; end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_WR_FOLLOWS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !s_ready); // R1
  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q || err_q != E_NONE) |-> !s_ready); // R1
  AST_WR_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |-> (32'(wr_addr) < cap)); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && hs && rem_q != 32'd1 && !start) |=> (wr_addr == $past(wr_addr) + 1'b1)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R11
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (err_q == E_NONE)); // R11
  AST_NO_WR_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != E_NONE) |-> !wr_valid); // R12
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != E_NONE && !start) |=> (err_q == $past(err_q))); // R12
endmodule

// File: tb/fwl_loader_test.sv
module fwl_loader_test;
  localparam int AW = 12;

  typedef struct packed {
    logic          sel;
    logic [AW-1:0] addr;
    logic [31:0]   data;
  } wr_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] engine_id = 4'd1;
  logic legacy_family = 1'b1;
  logic [31:0] img_bytes = '0;
  logic s_valid = 1'b0, wr_ready = 1'b1;
  logic [31:0] s_data = '0;
  logic s_ready, wr_valid, wr_sel, done;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0] err_code;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;
  logic [31:0] pay[$];
  logic [31:0] img[$];
  wr_t exp_q[$];
  wr_t mon_e;

  always #4 clk = ~clk;

  fwl_loader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .engine_id(engine_id),
    .legacy_family(legacy_family), .img_bytes(img_bytes),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .err_code(err_code)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] ent(input logic [7:0] t, input int off);
    return {t, off[23:0]};
  endfunction

  // scoreboard monitor: compares each accepted write with the queue head
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R12 unexpected write", {19'b0, wr_addr, wr_sel}, 32'hFFFFFFFF);
      end else begin
        mon_e = exp_q.pop_front();
        chk({wr_sel, wr_addr, wr_data} == mon_e, "R10 write",
            wr_data ^ {19'b0, wr_addr, wr_sel}, mon_e.data ^ {19'b0, mon_e.addr, mon_e.sel});
      end
    end
    if (rst_n && wr_valid && !wr_ready)
      chk(!s_ready, "R1 stall under back-pressure", {31'b0, s_ready}, 32'd0);
  end

  task automatic put_cb(input bit sel, input int addr, input int len, input int ndata,
                        input logic [31:0] base, input bit expect_wr);
    pay.push_back(addr);
    pay.push_back(len);
    for (int i = 0; i < ndata; i++) begin
      pay.push_back(base + i);
      if (expect_wr) exp_q.push_back({sel, AW'(addr + i), base + 32'(i)});
    end
  endtask

  task automatic make_image(input logic [31:0] idw, input bit swp, input int adj);
    img.delete();
    img.push_back(32'hFEEDF00D);
    img.push_back(idw);
    img.push_back(pay.size());
    foreach (pay[i]) img.push_back(pay[i]);
    if (swp) foreach (img[i]) img[i] = bswap(img[i]);
    img_bytes = img.size() * 4 + adj;
  endtask

  task automatic run(input string tag, input logic [3:0] exp_err, input bit exp_done,
                     input bit bub, input bit bp);
    int idx = 0;
    bit seen_done = 1'b0;
    bit hs;
    int cap = img.size() * 4 + 40;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int cyc = 0; cyc < cap; cyc++) begin
      s_valid = (idx < img.size()) && !(bub && (cyc % 4 == 2));
      s_data  = s_valid ? img[idx] : 32'h0;
      wr_ready = !(bp && (cyc % 3 == 1));
      @(negedge clk);
      if (cyc == 0) chk(err_code == 4'd0, {tag, " R12 start clears error"}, err_code, 0);
      hs = s_valid && s_ready;
      if (done) seen_done = 1'b1;
      @(posedge clk); #1;
      if (hs) idx++;
      if (seen_done || err_code != 4'd0) break;
    end
    s_valid = 1'b0; wr_ready = 1'b1;
    repeat (2) @(posedge clk);
    #1 s_valid = 1'b1; s_data = 32'hFEEDF00D;
    @(negedge clk);
    chk(!s_ready, {tag, " R1 no ready when finished"}, {31'b0, s_ready}, 0);
    chk(err_code == exp_err, {tag, " error code"}, err_code, exp_err);
    chk(seen_done == exp_done, {tag, " done pulse"}, seen_done, exp_done);
    chk(exp_q.size() == 0, {tag, " R10 all writes seen"}, exp_q.size(), 0);
    exp_q.delete();
    @(posedge clk); #1 s_valid = 1'b0;
  endtask

  task automatic good_two_blocks();
    pay.delete();
    pay.push_back(ent(8'h00, 3));
    pay.push_back(ent(8'h01, 9));
    pay.push_back(ent(8'h0F, 0));
    put_cb(1'b0, 32'h10, 3, 3, 32'hA000_0000, 1'b1);
    pay.push_back(32'hDEAD_BEEF);
    put_cb(1'b1, 32'h7FE, 2, 2, 32'h1234_5670, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!s_ready && !wr_valid && !done && err_code == 0, "R1 reset state",
        {s_ready, wr_valid, done, err_code}, 0);
    #1 rst_n = 1'b1;

    engine_id = 4'd1; legacy_family = 1'b1;
    good_two_blocks(); make_image(32'h0100_0102, 1'b0, 0);
    run("R2 R10 native image", 4'd0, 1'b1, 1'b0, 1'b0);

    good_two_blocks(); make_image(32'h0100_0102, 1'b1, 0);
    run("R2 R1 swapped image with stalls", 4'd0, 1'b1, 1'b1, 1'b1);

    pay.delete(); pay.push_back(ent(8'h0F, 0)); make_image(32'h0100_0000, 1'b0, 0);
    img[0] = 32'hFEEDF00E;
    run("R2 bad magic", 4'd1, 1'b0, 1'b0, 1'b0);

    pay.delete(); pay.push_back(ent(8'h0F, 0)); make_image(32'h0100_0000, 1'b0, 4);
    run("R3 size mismatch", 4'd2, 1'b0, 1'b0, 1'b0);

    pay.delete(); pay.push_back(ent(8'h0F, 0)); make_image(32'h0200_0000, 1'b0, 0);
    run("R4 engine mismatch", 4'd3, 1'b0, 1'b0, 1'b0);

    good_two_blocks(); exp_q.delete(); make_image(32'h1100_0000, 1'b0, 0);
    run("R4 newer image on legacy family", 4'd4, 1'b0, 1'b0, 1'b0);

    legacy_family = 1'b0;
    good_two_blocks(); make_image(32'h1100_0000, 1'b0, 0);
    run("R4 R9 newer image on newer family", 4'd0, 1'b1, 1'b0, 1'b1);
    legacy_family = 1'b1;

    pay.delete(); pay.push_back(ent(8'h00, 0)); pay.push_back(ent(8'h01, 0));
    make_image(32'h0100_0000, 1'b0, 0);
    run("R5 missing end entry", 4'd5, 1'b0, 1'b0, 1'b0);

    pay.delete();
    for (int i = 0; i < 9; i++) pay.push_back(ent(8'h00, 9));
    repeat (3) pay.push_back(32'h0);
    make_image(32'h0100_0000, 1'b0, 0);
    run("R5 table overflow", 4'd6, 1'b0, 1'b0, 1'b0);

    pay.delete(); pay.push_back(ent(8'h02, 2)); pay.push_back(ent(8'h0F, 0));
    repeat (2) pay.push_back(32'h0);
    make_image(32'h0100_0000, 1'b0, 0);
    run("R5 invalid block type", 4'd8, 1'b0, 1'b0, 1'b0);

    pay.delete(); pay.push_back(ent(8'h00, 1)); pay.push_back(ent(8'h0F, 0));
    repeat (2) pay.push_back(32'h0);
    make_image(32'h0100_0000, 1'b0, 0);
    run("R6 offset inside table", 4'd7, 1'b0, 1'b0, 1'b0);

    pay.delete(); pay.push_back(ent(8'h00, 3)); pay.push_back(ent(8'h00, 5));
    pay.push_back(ent(8'h0F, 0));
    put_cb(1'b0, 32'h40, 3, 3, 32'h5500_0000, 1'b1);
    repeat (2) pay.push_back(32'h0);
    make_image(32'h0100_0000, 1'b0, 0);
    run("R7 overlapping blocks", 4'd9, 1'b0, 1'b0, 1'b0);

    engine_id = 4'd0;
    pay.delete(); pay.push_back(ent(8'h00, 2)); pay.push_back(ent(8'h0F, 0));
    put_cb(1'b0, 32'hFFE, 2, 2, 32'h7700_0000, 1'b1);
    make_image(32'h0000_0000, 1'b0, 0);
    run("R9 engine 0 instruction top edge", 4'd0, 1'b1, 1'b0, 1'b0);

    engine_id = 4'd1;
    pay.delete(); pay.push_back(ent(8'h00, 2)); pay.push_back(ent(8'h0F, 0));
    put_cb(1'b0, 32'hFFE, 2, 2, 32'h7700_0000, 1'b0);
    make_image(32'h0100_0000, 1'b0, 0);
    run("R8 R9 engine 1 instruction overflow", 4'd10, 1'b0, 1'b0, 1'b0);

    pay.delete(); pay.push_back(ent(8'h01, 2)); pay.push_back(ent(8'h0F, 0));
    put_cb(1'b1, 32'h0, 5, 2, 32'h3300_0000, 1'b0);
    make_image(32'h0100_0000, 1'b0, 0);
    run("R8 block past image end", 4'd11, 1'b0, 1'b0, 1'b0);

    pay.delete(); pay.push_back(ent(8'h00, 3)); pay.push_back(ent(8'h01, 7));
    pay.push_back(ent(8'h0F, 0));
    put_cb(1'b0, 32'h20, 2, 2, 32'hC000_0000, 1'b1);
    put_cb(1'b1, 32'h7FF, 2, 2, 32'hC100_0000, 1'b0);
    make_image(32'h0100_0000, 1'b0, 0);
    run("R12 error after first block", 4'd10, 1'b0, 1'b0, 1'b0);

    pay.delete(); pay.push_back(ent(8'h0F, 0));
    make_image(32'h0100_0000, 1'b0, 0);
    run("R11 empty table", 4'd0, 1'b1, 1'b0, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule